// File: doc/BRIEF.md
# Transactional Line Tracker with Conflict PC

This block keeps the speculative state of every line of a small first-level cache that hosts hardware transactions. For each resident 64-byte line it holds a residency flag, the line address, a transactional-read mark, a transactional-write mark and a 12-bit tag. The tag takes the low 12 bits of the program counter of the instruction that first touched the line inside the current transaction. The core reports its loads and stores, each flagged as transactional or not, together with transaction begin and commit strobes. The coherence side presents snoops from other cores.

Conflicts are settled eagerly, and the requester always wins. When a snoop collides with local speculative state, the local transaction is killed. The block raises a one-cycle abort pulse with a 64-bit report, which software uses to find the instruction that opened the contended region. Commit drops all read and write marks. Abort drops them as well and also evicts every line that was written speculatively. Nontransactional accesses may make a line resident, but they never mark it and never lead to an abort.

Top module: `txline_tracker`

## Requirements
- R1: After reset the transaction is inactive, `abort_o`, `abort_report_o` and `snp_hit_o` are zero, and no line is resident.
- R2: `tx_begin_i` makes `tx_active_o` 1 at the next edge, and commit or abort makes it 0. A transactional access made while inactive, or in the same cycle as a commit, sets no marks.
- R3: A transactional load marks its line as read. A snoop read to that line does not conflict, and a snoop write to it does.
- R4: A transactional store marks its line as written. A snoop read or a snoop write to that line conflicts.
- R5: The PC tag is loaded only when a line passes from unmarked to marked. Later transactional accesses to a marked line leave the tag unchanged.
- R6: A conflict raises `abort_o` for exactly one cycle, at the edge that samples the snoop. In that cycle `abort_report_o[63:52]` holds the line's PC tag and `abort_report_o[51:0]` holds bits 51:0 of the snoop byte address. Otherwise the report is zero.
- R7: At an abort, every line loses its marks. Lines that carried a write mark become non-resident, and lines that were only read stay resident.
- R8: Commit clears every mark and leaves all lines resident, so later snoops to those lines cause no abort.
- R9: Nontransactional accesses install a line when needed but set no marks, so they never cause an abort.
- R10: Matching is done per 64-byte line. Byte addresses that differ only in bits 5:0 match the same line. The line index is taken from address bits 6 and up.
- R11: `snp_hit_o` shows, one cycle after a snoop, whether the snooped line was resident. A snoop to an absent or unmarked line never aborts.
- R12: An abort takes priority over a commit in the same cycle. A local access presented in the same cycle as a conflict is discarded.
- R13: The PC tag is not cleared at commit. It is replaced at the next transition of that line from unmarked to marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_begin_i | input | 1 | Start of a transaction |
| tx_commit_i | input | 1 | Commit of the running transaction |
| acc_valid_i | input | 1 | Local access present |
| acc_write_i | input | 1 | Local access is a store |
| acc_tx_i | input | 1 | Local access is transactional |
| acc_line_i | input | ADDR_W-6 | Line address (byte address bits ADDR_W-1:6) of the local access |
| acc_pc_i | input | 12 | Low 12 bits of the PC of the local access |
| snp_valid_i | input | 1 | Remote snoop present |
| snp_write_i | input | 1 | Snoop asks for write ownership |
| snp_addr_i | input | ADDR_W | Snoop byte address |
| tx_active_o | output | 1 | Transaction running |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_report_o | output | 64 | Packed PC tag and conflict address |
| snp_hit_o | output | 1 | Snooped line was resident |

## Verification
The assertions assume that the core never asks for a new line whose direct-mapped slot holds a different, still-marked line. Capacity overflow is outside this block, so such an access is dropped silently. They also assume that begin is not raised while a transaction is already running. The stimulus picks addresses that sit in distinct slots, or that reuse a slot only once its occupant carries no marks, and it issues begin only after a commit or an abort. Under these conditions, any marked line implies a running transaction, and an abort can never follow another abort in the next cycle.

// File: rtl/ttrk_pkg.sv
// ttrk_pkg: shared constants, per-line flag type and conflict rule for the
// transactional line tracker. Assumes 64-byte lines and a 64-bit report.
package ttrk_pkg;

    localparam int LINE_OFF    = 6;   // byte-offset bits inside a 64-byte line
    localparam int PCTAG_W     = 12;  // retained low PC bits per line
    localparam int REP_ADDR_W  = 52;  // address bits carried in the report
    localparam int REPORT_W    = PCTAG_W + REP_ADDR_W;

    typedef struct packed {
        logic present;   // line resident in the tracker
        logic rd;        // transactionally read
        logic wr;        // transactionally written
    } line_flags_t;

    // Requester-wins rule: remote write hits any mark, remote read hits a write mark.
    function automatic logic snoop_conflicts(line_flags_t f, logic remote_wr);
        return f.present && (remote_wr ? (f.rd || f.wr) : f.wr);
    endfunction

endpackage

// File: rtl/ttrk_line_array.sv
// ttrk_line_array: direct-mapped per-line state (residency, line tag, read and
// write marks, first-access PC tag). Assumes the caller already gates accesses
// with abort, and that capacity overflow is handled elsewhere (a new line
// mapping onto a marked slot is dropped).
module ttrk_line_array
    import ttrk_pkg::*;
#(
    parameter int ADDR_W    = 56,
    parameter int NUM_LINES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   acc_en_i,
    input  logic                                   acc_spec_i,
    input  logic                                   acc_write_i,
    input  logic [ADDR_W-LINE_OFF-1:0]             acc_line_i,
    input  logic [PCTAG_W-1:0]                     acc_pc_i,
    input  logic                                   clr_commit_i,
    input  logic                                   clr_abort_i,
    output line_flags_t [NUM_LINES-1:0]            flags_o,
    output logic [NUM_LINES-1:0][ADDR_W-LINE_OFF-$clog2(NUM_LINES)-1:0] ltag_o,
    output logic [NUM_LINES-1:0][PCTAG_W-1:0]      pctag_o
);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int LINE_W = ADDR_W - LINE_OFF;
    localparam int TAG_W  = LINE_W - IDX_W;

    logic [IDX_W-1:0] acc_idx;
    logic [TAG_W-1:0] acc_tag;

    // Split the access line address into slot index and stored tag.
    always_comb begin
        acc_idx = acc_line_i[IDX_W-1:0];
        acc_tag = acc_line_i[LINE_W-1:IDX_W];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic sel;
        logic spec;
        logic same;

        // Decode whether this slot is addressed and its current condition.
        always_comb begin
            sel  = acc_en_i && (acc_idx == IDX_W'(g));
            spec = flags_o[g].rd || flags_o[g].wr;
            same = flags_o[g].present && (ltag_o[g] == acc_tag);
        end

        // Update marks, residency and the first-access PC tag of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_o[g] <= '0;
                ltag_o[g]  <= '0;
                pctag_o[g] <= '0;
            end else if (clr_abort_i) begin
                flags_o[g].present <= flags_o[g].present && !flags_o[g].wr;
                flags_o[g].rd      <= 1'b0;
                flags_o[g].wr      <= 1'b0;
            end else if (clr_commit_i) begin
                flags_o[g].rd <= 1'b0;
                flags_o[g].wr <= 1'b0;
            end else if (sel) begin
                if (same) begin
                    if (acc_spec_i) begin
                        flags_o[g].rd <= flags_o[g].rd || !acc_write_i;
                        flags_o[g].wr <= flags_o[g].wr || acc_write_i;
                        if (!spec) begin
                            pctag_o[g] <= acc_pc_i;
                        end
                    end
                end else if (!spec) begin
                    flags_o[g].present <= 1'b1;
                    flags_o[g].rd      <= acc_spec_i && !acc_write_i;
                    flags_o[g].wr      <= acc_spec_i && acc_write_i;
                    ltag_o[g]          <= acc_tag;
                    if (acc_spec_i) begin
                        pctag_o[g] <= acc_pc_i;
                    end
                end
            end
        end

        // R5: while a line stays marked its PC tag must not move.
        a_r5_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(flags_o[g].rd || flags_o[g].wr) && (flags_o[g].rd || flags_o[g].wr))
            |-> $stable(pctag_o[g]));
    end

endmodule

// File: rtl/ttrk_snoop_check.sv
// ttrk_snoop_check: compares a remote snoop against the line array and
// decides residency, conflict and the PC tag to report. Purely combinational;
// assumes the array is direct-mapped, so at most one slot can match.
module ttrk_snoop_check
    import ttrk_pkg::*;
#(
    parameter int ADDR_W    = 56,
    parameter int NUM_LINES = 16
) (
    input  logic                                   snp_valid_i,
    input  logic                                   snp_write_i,
    input  logic [ADDR_W-LINE_OFF-1:0]             snp_line_i,
    input  line_flags_t [NUM_LINES-1:0]            flags_i,
    input  logic [NUM_LINES-1:0][ADDR_W-LINE_OFF-$clog2(NUM_LINES)-1:0] ltag_i,
    input  logic [NUM_LINES-1:0][PCTAG_W-1:0]      pctag_i,
    output logic                                   hit_o,
    output logic                                   conflict_o,
    output logic [PCTAG_W-1:0]                     conf_pc_o
);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int LINE_W = ADDR_W - LINE_OFF;
    localparam int TAG_W  = LINE_W - IDX_W;

    logic [IDX_W-1:0]     snp_idx;
    logic [TAG_W-1:0]     snp_tag;
    logic [NUM_LINES-1:0] match_vec;
    logic [NUM_LINES-1:0] conf_vec;

    // Split the snooped line address into slot index and tag.
    always_comb begin
        snp_idx = snp_line_i[IDX_W-1:0];
        snp_tag = snp_line_i[LINE_W-1:IDX_W];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        // Per-slot residency match and conflict decision.
        always_comb begin
            match_vec[g] = snp_valid_i && (snp_idx == IDX_W'(g)) &&
                           flags_i[g].present && (ltag_i[g] == snp_tag);
            conf_vec[g]  = match_vec[g] && snoop_conflicts(flags_i[g], snp_write_i);
        end
    end

    // Reduce slot results and select the PC tag of the conflicting slot.
    always_comb begin
        hit_o      = |match_vec;
        conflict_o = |conf_vec;
        conf_pc_o  = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (conf_vec[i]) begin
                conf_pc_o = conf_pc_o | pctag_i[i];
            end
        end
    end

endmodule

// File: rtl/ttrk_abort_report.sv
// ttrk_abort_report: registers the abort pulse, the packed abort report
// (PC tag above the low 52 address bits) and the snoop residency flag.
// Assumes conflict_i is already qualified by a valid snoop.
module ttrk_abort_report
    import ttrk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  conflict_i,
    input  logic                  hit_i,
    input  logic [PCTAG_W-1:0]    pc_i,
    input  logic [REP_ADDR_W-1:0] addr_i,
    output logic                  abort_o,
    output logic [REPORT_W-1:0]   report_o,
    output logic                  hit_o
);
    // Capture one-cycle abort and report, and the residency answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_o  <= 1'b0;
            report_o <= '0;
            hit_o    <= 1'b0;
        end else begin
            abort_o  <= conflict_i;
            report_o <= conflict_i ? {pc_i, addr_i} : '0;
            hit_o    <= hit_i;
        end
    end

endmodule

// File: rtl/txline_tracker.sv
// txline_tracker: top of the transactional line tracker. Holds the running
// state of the local transaction, gates local accesses, and ties the line
// array, snoop check and abort report together. Assumes ADDR_W >= 52 and
// that begin is not raised while a transaction is running.
module txline_tracker
    import ttrk_pkg::*;
#(
    parameter int ADDR_W    = 56,
    parameter int NUM_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_begin_i,
    input  logic                       tx_commit_i,
    input  logic                       acc_valid_i,
    input  logic                       acc_write_i,
    input  logic                       acc_tx_i,
    input  logic [ADDR_W-LINE_OFF-1:0] acc_line_i,
    input  logic [PCTAG_W-1:0]         acc_pc_i,
    input  logic                       snp_valid_i,
    input  logic                       snp_write_i,
    input  logic [ADDR_W-1:0]          snp_addr_i,
    output logic                       tx_active_o,
    output logic                       abort_o,
    output logic [REPORT_W-1:0]        abort_report_o,
    output logic                       snp_hit_o
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - LINE_OFF - IDX_W;

    line_flags_t [NUM_LINES-1:0]            flags;
    logic [NUM_LINES-1:0][TAG_W-1:0]        ltags;
    logic [NUM_LINES-1:0][PCTAG_W-1:0]      pctags;
    logic                                   conflict;
    logic                                   snp_hit;
    logic [PCTAG_W-1:0]                     conf_pc;
    logic                                   acc_en;
    logic                                   acc_spec;
    logic                                   any_marked;

    // Gate local accesses: a conflict discards them, commit ends tracking.
    always_comb begin
        acc_en   = acc_valid_i && !conflict;
        acc_spec = acc_tx_i && tx_active_o && !tx_commit_i;
    end

    // Transaction running state; abort outranks commit, commit outranks begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_active_o <= 1'b0;
        end else if (conflict || tx_commit_i) begin
            tx_active_o <= 1'b0;
        end else if (tx_begin_i) begin
            tx_active_o <= 1'b1;
        end
    end

    ttrk_line_array #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_en_i     (acc_en),
        .acc_spec_i   (acc_spec),
        .acc_write_i  (acc_write_i),
        .acc_line_i   (acc_line_i),
        .acc_pc_i     (acc_pc_i),
        .clr_commit_i (tx_commit_i),
        .clr_abort_i  (conflict),
        .flags_o      (flags),
        .ltag_o       (ltags),
        .pctag_o      (pctags)
    );

    ttrk_snoop_check #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_snoop (
        .snp_valid_i (snp_valid_i),
        .snp_write_i (snp_write_i),
        .snp_line_i  (snp_addr_i[ADDR_W-1:LINE_OFF]),
        .flags_i     (flags),
        .ltag_i      (ltags),
        .pctag_i     (pctags),
        .hit_o       (snp_hit),
        .conflict_o  (conflict),
        .conf_pc_o   (conf_pc)
    );

    ttrk_abort_report u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .conflict_i (conflict),
        .hit_i      (snp_hit),
        .pc_i       (conf_pc),
        .addr_i     (snp_addr_i[REP_ADDR_W-1:0]),
        .abort_o    (abort_o),
        .report_o   (abort_report_o),
        .hit_o      (snp_hit_o)
    );

    // Summarise whether any line currently carries a mark.
    always_comb begin
        any_marked = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            any_marked = any_marked | flags[i].rd | flags[i].wr;
        end
    end

    // R2: an abort can only follow a running transaction.
    a_r2_abort_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(tx_active_o));

    // R7: the abort pulse coincides with the transaction ending.
    a_r7_abort_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !tx_active_o);

    // R6: abort is a single-cycle pulse.
    a_r6_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R9: marks exist only inside a running transaction.
    a_r9_marks_need_active: assert property (@(posedge clk) disable iff (!rst_n)
        any_marked |-> tx_active_o);

endmodule

// File: tb/txline_tracker_tb_top.sv
`timescale 1ns/1ps
module txline_tracker_tb_top;
    localparam int ADDR_W = 56;
    localparam int LW     = ADDR_W - 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_begin_i = 1'b0, tx_commit_i = 1'b0;
    logic              acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_tx_i = 1'b0;
    logic [LW-1:0]     acc_line_i = '0;
    logic [11:0]       acc_pc_i = '0;
    logic              snp_valid_i = 1'b0, snp_write_i = 1'b0;
    logic [ADDR_W-1:0] snp_addr_i = '0;
    logic              tx_active_o, abort_o, snp_hit_o;
    logic [63:0]       abort_report_o;

    always #2 clk = ~clk;   // 250 MHz

    txline_tracker #(.ADDR_W(ADDR_W), .NUM_LINES(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_begin_i(tx_begin_i), .tx_commit_i(tx_commit_i),
        .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_tx_i(acc_tx_i),
        .acc_line_i(acc_line_i), .acc_pc_i(acc_pc_i),
        .snp_valid_i(snp_valid_i), .snp_write_i(snp_write_i), .snp_addr_i(snp_addr_i),
        .tx_active_o(tx_active_o), .abort_o(abort_o),
        .abort_report_o(abort_report_o), .snp_hit_o(snp_hit_o)
    );

    typedef struct {
        logic        act;
        logic        ab;
        logic [63:0] rep;
        logic        hit;
        string       req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    // Slot 1, slot 3, and a second tag on slot 1.
    localparam logic [ADDR_W-1:0] A = 56'h00_00AB_CDE0_0040;
    localparam logic [ADDR_W-1:0] B = 56'h00_0012_3450_00C0;
    localparam logic [ADDR_W-1:0] C = 56'h00_00AB_CDE0_0440;

    function automatic logic [63:0] rep(logic [11:0] pc, logic [ADDR_W-1:0] a);
        return {pc, a[51:0]};
    endfunction

    // Driver: present one cycle of stimulus and queue the outputs expected after it.
    task automatic step(input logic b, input logic c,
                        input logic av, input logic aw, input logic at,
                        input logic [ADDR_W-1:0] aa, input logic [11:0] pc,
                        input logic sv, input logic sw, input logic [ADDR_W-1:0] sa,
                        input logic e_act, input logic e_ab, input logic [63:0] e_rep,
                        input logic e_hit, input string req);
        exp_t e;
        @(negedge clk);
        tx_begin_i  = b;  tx_commit_i = c;
        acc_valid_i = av; acc_write_i = aw; acc_tx_i = at;
        acc_line_i  = aa[ADDR_W-1:6]; acc_pc_i = pc;
        snp_valid_i = sv; snp_write_i = sw; snp_addr_i = sa;
        e.act = e_act; e.ab = e_ab; e.rep = e_rep; e.hit = e_hit; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare outputs just after each edge with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (tx_active_o !== e.act || abort_o !== e.ab ||
                    abort_report_o !== e.rep || snp_hit_o !== e.hit) begin
                    bad++;
                    $display("FAIL %s: act/abort/report/hit got %0b/%0b/%h/%0b exp %0b/%0b/%h/%0b",
                             e.req, tx_active_o, abort_o, abort_report_o, snp_hit_o,
                             e.act, e.ab, e.rep, e.hit);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //   b c  av aw at addr pc       sv sw snp      act ab rep               hit
        step(0,0, 0,0,0, A, 12'h0,   0,0,A,       0,0,64'h0,0, "R1 reset state");
        step(0,0, 0,0,0, A, 12'h0,   1,1,A,       0,0,64'h0,0, "R11 snoop absent line");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 1,0,1, A, 12'h123, 0,0,A,       1,0,64'h0,0, "R3 tx load");
        step(0,0, 0,0,0, A, 12'h0,   1,0,A+10,    1,0,64'h0,1, "R3 R10 snoop read of read line");
        step(0,0, 1,1,1, A, 12'h999, 0,0,A,       1,0,64'h0,0, "R5 later store keeps tag");
        step(0,0, 0,0,0, A, 12'h0,   1,0,A+63,    0,1,rep(12'h123,A+63),1, "R4 R5 R6 snoop read of written line");
        step(0,0, 0,0,0, A, 12'h0,   0,0,A,       0,0,64'h0,0, "R6 single pulse");
        step(0,0, 0,0,0, A, 12'h0,   1,0,A,       0,0,64'h0,0, "R7 written line evicted");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 1,0,1, B, 12'h0AA, 0,0,A,       1,0,64'h0,0, "R3 tx load B");
        step(0,0, 1,1,0, C, 12'h0BB, 0,0,A,       1,0,64'h0,0, "R9 nontx store C");
        step(0,0, 0,0,0, A, 12'h0,   1,1,C,       1,0,64'h0,1, "R9 nontx line no abort");
        step(0,0, 0,0,0, A, 12'h0,   1,1,B+5,     0,1,rep(12'h0AA,B+5),1, "R3 snoop write of read line");
        step(0,0, 0,0,0, A, 12'h0,   1,0,B,       0,0,64'h0,1, "R7 read line stays");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 1,1,1, B, 12'h777, 0,0,A,       1,0,64'h0,0, "R13 tx store B");
        step(0,1, 0,0,0, A, 12'h0,   0,0,A,       0,0,64'h0,0, "R8 commit");
        step(0,0, 0,0,0, A, 12'h0,   1,1,B,       0,0,64'h0,1, "R8 no abort after commit");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 1,0,1, B, 12'h321, 0,0,A,       1,0,64'h0,0, "R13 tag reload");
        step(0,0, 0,0,0, A, 12'h0,   1,1,B,       0,1,rep(12'h321,B),1, "R13 new tag reported");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 1,0,1, A, 12'h444, 0,0,A,       1,0,64'h0,0, "R12 tx load A");
        step(0,1, 0,0,0, A, 12'h0,   1,1,A,       0,1,rep(12'h444,A),1, "R12 abort beats commit");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 1,0,1, B, 12'h055, 0,0,A,       1,0,64'h0,0, "R12 tx load B");
        step(0,0, 1,1,1, A, 12'h066, 1,1,B,       0,1,rep(12'h055,B),1, "R12 abort with access");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 0,0,0, A, 12'h0,   1,1,A,       1,0,64'h0,1, "R12 discarded access left no mark");
        step(0,1, 0,0,0, A, 12'h0,   0,0,A,       0,0,64'h0,0, "R8 commit");
        step(0,0, 1,0,1, B, 12'h0CC, 0,0,A,       0,0,64'h0,0, "R2 tx load while inactive");
        step(1,0, 0,0,0, A, 12'h0,   0,0,A,       1,0,64'h0,0, "R2 begin");
        step(0,0, 0,0,0, A, 12'h0,   1,1,B,       1,0,64'h0,1, "R2 inactive access unmarked");
        step(0,1, 0,0,0, A, 12'h0,   0,0,A,       0,0,64'h0,0, "R8 commit");
        step(0,0, 0,0,0, A, 12'h0,   0,0,A,       0,0,64'h0,0, "R1 idle");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule